// File: doc/BRIEF.md
# Backplane Interrupt Requester

This block lets local software raise one interrupt on a shared backplane. A single register write supplies a request level and a vector byte. The block then pulls the matching active-low request line low and keeps it low until a bus master acknowledges that level. During the acknowledge the block hands back the stored vector. The request has no timeout: if nobody acknowledges it, the line stays low for good.

Only one request can be outstanding. Any write that arrives while a request is pending is discarded, whatever its level. This means the block never drives more than one line and never needs more than one vector register. An acknowledge that does not match the pending level, or that arrives when nothing is pending, is passed down the daisy chain. Software can poll a pending flag before it writes. No enable bit is involved: the write on its own starts the request.

Top module: `irq_bus_requester`

## Requirements
- R1: After reset all request lines are high, the pending flag is 0, and the data-acknowledge, vector-drive and acknowledge-out outputs are 0.
- R2: With nothing pending, a write with level L in 1..NUM_LINES drives `irq_n[L-1]` low on the clock edge that samples the write. No other control is needed.
- R3: At no time is more than one bit of `irq_n` low.
- R4: A write with level 0 changes nothing. The lines stay high and the pending flag stays 0.
- R5: While a request is pending, every write is ignored. This applies on all levels, and both the driven line and the stored vector are kept.
- R6: A pending request stays asserted for any number of cycles until a matching acknowledge arrives.
- R7: An acknowledge with `iack_in` high and `iack_level` equal to the pending level has the following effect on the next edge. `dtack` and `vec_oe` go high for exactly one cycle and `vec_data` carries the stored vector. On the same edge the request line is released and the pending flag clears.
- R8: An acknowledge whose level does not match, or that arrives while idle, sets `iack_out` high on the next edge. In that case `dtack` and `vec_oe` stay 0, `vec_data` stays 0, and any pending request is kept.
- R9: A write in the same cycle as the releasing acknowledge is ignored. A write presented in the cycle right after the release is accepted.
- R10: `status_pending` is 1 exactly when one request line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_level | input | LVL_W | Requested level, 0 means no request |
| wr_vector | input | VEC_W | Vector byte to return on acknowledge |
| status_pending | output | 1 | A request is outstanding |
| irq_n | output | NUM_LINES | Active-low request lines, bit i is level i+1 |
| iack_in | input | 1 | Daisy-chain acknowledge strobe in |
| iack_level | input | LVL_W | Level being acknowledged |
| iack_out | output | 1 | Strobe passed on down the chain |
| vec_data | output | VEC_W | Vector returned on a matching acknowledge |
| vec_oe | output | 1 | Vector data is being driven |
| dtack | output | 1 | Data-acknowledge pulse |

## Verification
The bench builds the block with its default seven lines and an 8-bit vector. This brings every level, from the lowest to the highest line, within reach of a full raise-and-acknowledge round. Seven lines also leave room to hold one level while requesting or acknowledging a different level, which is the case where drops and pass-throughs happen. A hold of a thousand cycles shows that the request has no timeout. Writes placed on the release cycle and on the cycle after it pin down exactly where a new request becomes acceptable.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

    localparam int unsigned DEF_LINES = 7;
    localparam int unsigned DEF_VEC_W = 8;

    typedef enum logic [1:0] {
        ACK_NONE = 2'd0,
        ACK_HIT  = 2'd1,
        ACK_PASS = 2'd2
    } ack_kind_e;

    typedef struct packed {
        logic dtack;
        logic drive;
        logic pass;
    } ack_resp_t;

    function automatic ack_resp_t resp_of(input ack_kind_e k);
        ack_resp_t r;
        r.dtack = (k == ACK_HIT);
        r.drive = (k == ACK_HIT);
        r.pass  = (k == ACK_PASS);
        return r;
    endfunction

endpackage

// File: rtl/irq_req_store.sv
module irq_req_store #(
    parameter int unsigned NUM_LINES = 7,
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned LVL_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_level,
    input  logic [VEC_W-1:0] wr_vector,
    input  logic             clr,
    output logic             pending,
    output logic [LVL_W-1:0] level,
    output logic [VEC_W-1:0] vector
);

    logic accept;

    always_comb begin
        accept = wr_en && !pending && (wr_level != '0)
                 && (wr_level <= LVL_W'(NUM_LINES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            level   <= '0;
            vector  <= '0;
        end else if (clr) begin
            pending <= 1'b0;
        end else if (accept) begin
            pending <= 1'b1;
            level   <= wr_level;
            vector  <= wr_vector;
        end
    end

    p_level0_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (!pending && wr_en && wr_level == '0) |=> !pending);

    p_busy_keeps_vector_r5: assert property (@(posedge clk) disable iff (rst)
        (pending && wr_en) |=> ($stable(vector) && $stable(level)));

    p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (pending && !clr) |=> pending);

endmodule

// File: rtl/irq_ack_resp.sv
module irq_ack_resp
    import irq_req_pkg::*;
#(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iack_in,
    input  logic [LVL_W-1:0] iack_level,
    input  logic             pending,
    input  logic [LVL_W-1:0] level,
    input  logic [VEC_W-1:0] vector,
    output logic             hit,
    output logic             dtack,
    output logic             vec_oe,
    output logic [VEC_W-1:0] vec_data,
    output logic             iack_out
);

    ack_kind_e kind;
    ack_resp_t nxt;

    always_comb begin
        if (!iack_in)
            kind = ACK_NONE;
        else if (pending && iack_level == level)
            kind = ACK_HIT;
        else
            kind = ACK_PASS;
        nxt = resp_of(kind);
        hit = (kind == ACK_HIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dtack    <= 1'b0;
            vec_oe   <= 1'b0;
            vec_data <= '0;
            iack_out <= 1'b0;
        end else begin
            dtack    <= nxt.dtack;
            vec_oe   <= nxt.drive;
            vec_data <= nxt.drive ? vector : '0;
            iack_out <= nxt.pass;
        end
    end

    p_dtack_single_r7: assert property (@(posedge clk) disable iff (rst)
        dtack |=> !dtack);

    p_dtack_with_drive_r7: assert property (@(posedge clk) disable iff (rst)
        dtack |-> vec_oe);

    p_pass_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
        iack_out |-> (!dtack && !vec_oe && vec_data == '0));

endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive #(
    parameter int unsigned NUM_LINES = 7,
    parameter int unsigned LVL_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pending,
    input  logic [LVL_W-1:0]     level,
    output logic [NUM_LINES-1:0] irq_n
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign irq_n[i] = ~(pending && (level == LVL_W'(i + 1)));
    end

    p_one_line_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(~irq_n) <= 1);

endmodule

// File: rtl/irq_bus_requester.sv
module irq_bus_requester #(
    parameter int unsigned NUM_LINES = irq_req_pkg::DEF_LINES,
    parameter int unsigned VEC_W     = irq_req_pkg::DEF_VEC_W,
    localparam int unsigned LVL_W    = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [LVL_W-1:0]     wr_level,
    input  logic [VEC_W-1:0]     wr_vector,
    output logic                 status_pending,
    output logic [NUM_LINES-1:0] irq_n,
    input  logic                 iack_in,
    input  logic [LVL_W-1:0]     iack_level,
    output logic                 iack_out,
    output logic [VEC_W-1:0]     vec_data,
    output logic                 vec_oe,
    output logic                 dtack
);

    logic             pend_q;
    logic [LVL_W-1:0] lvl_q;
    logic [VEC_W-1:0] vec_q;
    logic             ack_hit;

    irq_req_store #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_level(wr_level), .wr_vector(wr_vector),
        .clr(ack_hit),
        .pending(pend_q), .level(lvl_q), .vector(vec_q)
    );

    irq_ack_resp #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_ack (
        .clk(clk), .rst(rst),
        .iack_in(iack_in), .iack_level(iack_level),
        .pending(pend_q), .level(lvl_q), .vector(vec_q),
        .hit(ack_hit),
        .dtack(dtack), .vec_oe(vec_oe), .vec_data(vec_data),
        .iack_out(iack_out)
    );

    irq_line_drive #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_lines (
        .clk(clk), .rst(rst),
        .pending(pend_q), .level(lvl_q),
        .irq_n(irq_n)
    );

    assign status_pending = pend_q;

    p_status_matches_lines_r10: assert property (@(posedge clk) disable iff (rst)
        status_pending == (irq_n != {NUM_LINES{1'b1}}));

    p_release_on_dtack_r7: assert property (@(posedge clk) disable iff (rst)
        dtack |-> (irq_n == {NUM_LINES{1'b1}}));

endmodule

// File: tb/sim_irq_bus_requester.sv
module sim_irq_bus_requester;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_level = '0;
    logic [7:0] wr_vector = '0;
    logic       status_pending;
    logic [6:0] irq_n;
    logic       iack_in = 1'b0;
    logic [2:0] iack_level = '0;
    logic       iack_out;
    logic [7:0] vec_data;
    logic       vec_oe;
    logic       dtack;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_bus_requester u0 (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_level(wr_level), .wr_vector(wr_vector),
        .status_pending(status_pending), .irq_n(irq_n),
        .iack_in(iack_in), .iack_level(iack_level), .iack_out(iack_out),
        .vec_data(vec_data), .vec_oe(vec_oe), .dtack(dtack)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [6:0] line_of(input int lv);
        return ~(7'd1 << (lv - 1));
    endfunction

    task automatic do_write(input int lv, input int vec);
        wr_en = 1'b1; wr_level = 3'(lv); wr_vector = 8'(vec);
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_ack(input int lv);
        iack_in = 1'b1; iack_level = 3'(lv);
        step();
        iack_in = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "irq_n", 32'(irq_n), 32'h7f);
        check("R1", "pending", 32'(status_pending), 0);
        check("R1", "dtack", 32'(dtack), 0);
        check("R1", "vec_oe", 32'(vec_oe), 0);
        check("R1", "iack_out", 32'(iack_out), 0);
    endtask

    task automatic t_all_levels();
        for (int lv = 1; lv <= 7; lv++) begin
            int vec = 8'h10 + lv * 3;
            do_write(lv, vec);
            check("R2", "line low", 32'(irq_n), 32'(line_of(lv)));
            check("R10", "pending set", 32'(status_pending), 1);
            do_ack(lv);
            check("R7", "dtack", 32'(dtack), 1);
            check("R7", "vec_oe", 32'(vec_oe), 1);
            check("R7", "vector", 32'(vec_data), 32'(vec));
            check("R7", "released", 32'(irq_n), 32'h7f);
            check("R10", "pending clear", 32'(status_pending), 0);
            step();
            check("R7", "dtack one pulse", 32'(dtack), 0);
            check("R7", "vec_oe one pulse", 32'(vec_oe), 0);
        end
    endtask

    task automatic t_level_zero();
        do_write(0, 8'h55);
        check("R4", "lines idle", 32'(irq_n), 32'h7f);
        check("R4", "not pending", 32'(status_pending), 0);
    endtask

    task automatic t_busy_drop();
        do_write(3, 8'ha5);
        do_write(5, 8'h3c);
        check("R5", "first line kept", 32'(irq_n), 32'(line_of(3)));
        check("R3", "one line only", 32'($countones(~irq_n)), 1);
        do_ack(5);
        check("R8", "mismatch passed", 32'(iack_out), 1);
        check("R8", "mismatch no dtack", 32'(dtack), 0);
        check("R8", "request kept", 32'(irq_n), 32'(line_of(3)));
        step();
        do_ack(3);
        check("R5", "vector not overwritten", 32'(vec_data), 32'ha5);
        step();
    endtask

    task automatic t_idle_ack();
        do_ack(4);
        check("R8", "idle passed", 32'(iack_out), 1);
        check("R8", "idle no drive", 32'(vec_oe), 0);
        check("R8", "idle data zero", 32'(vec_data), 0);
        step();
        check("R8", "pass ends", 32'(iack_out), 0);
    endtask

    task automatic t_no_timeout();
        do_write(7, 8'h81);
        repeat (1000) step();
        check("R6", "still asserted", 32'(irq_n), 32'(line_of(7)));
        check("R6", "still pending", 32'(status_pending), 1);
        do_ack(7);
        check("R6", "vector after hold", 32'(vec_data), 32'h81);
        step();
    endtask

    task automatic t_rearm();
        do_write(2, 8'h11);
        wr_en = 1'b1; wr_level = 3'd6; wr_vector = 8'h99;
        iack_in = 1'b1; iack_level = 3'd2;
        step();
        iack_in = 1'b0; wr_en = 1'b0;
        check("R9", "same-cycle write dropped", 32'(irq_n), 32'h7f);
        check("R9", "ack vector", 32'(vec_data), 32'h11);
        do_write(6, 8'h66);
        check("R9", "next-cycle write taken", 32'(irq_n), 32'(line_of(6)));
        do_ack(6);
        check("R9", "new vector", 32'(vec_data), 32'h66);
        step();
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_all_levels();
        t_level_zero();
        t_busy_drop();
        t_idle_ack();
        t_no_timeout();
        t_rearm();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule